// File: doc/BRIEF.md
# Idle Standby Timer Bank

A bank of per-device idle countdown timers that raises a standby interrupt request once a device has gone unused for a programmed time. Each device has its own 8-bit reload value, an enable bit and an access-detect pulse. All timers step on one shared coarse tick strobe, for example one tick every 8 seconds. The usable time-out therefore runs from 1 to 255 ticks. A global freeze input halts every timer and keeps its count, so a long service routine does not lose idle time.

An expiry sets a sticky per-device status bit and a sticky summary bit. Software clears these by writing 1. The interrupt request output is the OR of every status bit whose device is still enabled. Decoding device accesses, generating the tick and delivering the interrupt to the CPU are done outside this block.

Top module: `idle_standby_bank`

## Requirements
- R1: A timer changes its count only in a cycle where `tick_i` is high. It steps down by exactly one per tick cycle, and cycles without a tick leave it unchanged.
- R2: With a reload value N from 1 to 255, the device's status bit reads 1 after the Nth tick cycle following the reload and reads 0 before that cycle.
- R3: A reload value of 0 leaves the timer unarmed. It never sets status, whatever the number of ticks.
- R4: A timer reloads its count from its reload value when its `access_i` bit is high. It also reloads in the first cycle in which its `en_i` bit is 1 after being 0.
- R5: While `freeze_i` is high, ticks have no effect on any timer. When freeze drops, counting resumes from the held value.
- R6: An expiry sets that device's `stat_o` bit and also sets `sum_stat_o`, on the clock edge of the expiring tick.
- R7: A timer whose `en_i` bit is 0 does not count and never sets status.
- R8: After expiry a timer stays at zero. Once its status is cleared, further ticks set no status until an access or a re-enable reloads it.
- R9: Status bits are sticky. A 1 on `clr_i[d]` clears `stat_o[d]`, and a 1 on `clr_sum_i` clears `sum_stat_o`. Other bits are unaffected.
- R10: `smi_o` is high exactly when at least one device has both its `stat_o` bit and its `en_i` bit set.
- R11: When an access and an expiring tick fall in the same cycle, the timer reloads and no status is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Shared countdown strobe, one step per high cycle |
| freeze_i | input | 1 | Holds all timers while high |
| en_i | input | N_DEV | Per-device timer enable |
| access_i | input | N_DEV | Per-device access pulse, reloads the timer |
| reload_i | input | N_DEV*CNT_W | Reload values; device d uses bits [d*CNT_W +: CNT_W] |
| clr_i | input | N_DEV | Write-1-to-clear for per-device status |
| clr_sum_i | input | 1 | Write-1-to-clear for summary status |
| stat_o | output | N_DEV | Sticky per-device expiry status |
| sum_stat_o | output | 1 | Sticky summary expiry status |
| smi_o | output | 1 | Standby interrupt request |

## Verification
The embedded properties assume that every input is synchronous to `clk_i` and free of X after reset. They also assume that a reload value is compared against the value that was present in the cycle of the reload event. No property assumes anything about how ticks are spaced, so ticks may arrive back to back or with long gaps.

The bench changes inputs only on the falling clock edge and drives tick, access and clear as single-cycle pulses. The reload values are held steady for the whole of each countdown. The expected status for each count is computed arithmetically from the reload value and the number of ticks applied.

// File: rtl/idle_stby_pkg.sv
package idle_stby_pkg;
  typedef enum logic [1:0] {
    EV_HOLD = 2'd0,
    EV_LOAD = 2'd1,
    EV_STEP = 2'd2
  } tmr_ev_e;
endpackage

// File: rtl/idle_timer.sv
module idle_timer
  import idle_stby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             en_i,
  input  logic             access_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load;
  logic             step;
  tmr_ev_e          ev;

  always_comb begin
    load = access_i | (en_i & ~en_q);
    step = en_i & tick_i & ~freeze_i & (cnt_q != '0);
    if (load)      ev = EV_LOAD;
    else if (step) ev = EV_STEP;
    else           ev = EV_HOLD;
    // access has priority over the final step (R11)
    expire_o = (ev == EV_STEP) && (cnt_q == ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= en_i;
      unique case (ev)
        EV_LOAD: cnt_q <= reload_i;
        EV_STEP: cnt_q <= cnt_q - ONE;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R5
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !access_i && !(en_i && !en_q)) |=> $stable(cnt_q));

  // R1
  tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && !freeze_i && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R4
  access_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i |=> (cnt_q == $past(reload_i)));

  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  // R7
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !access_i) |=> $stable(cnt_q));
endmodule

// File: rtl/standby_status.sv
module standby_status #(
  parameter int N_DEV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] expire_i,
  input  logic [N_DEV-1:0] clr_i,
  input  logic             clr_sum_i,
  input  logic [N_DEV-1:0] en_i,
  output logic [N_DEV-1:0] stat_o,
  output logic             sum_o,
  output logic             smi_o
);
  logic [N_DEV-1:0] stat_q;
  logic             sum_q;

  // new expiry wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      sum_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | expire_i;
      sum_q  <= (sum_q & ~clr_sum_i) | (|expire_i);
    end
  end

  assign stat_o = stat_q;
  assign sum_o  = sum_q;
  assign smi_o  = |(stat_q & en_i);

  // R9
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_q & ~clr_i)) |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));

  // R6
  dev_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|expire_i) |=> ((stat_q & $past(expire_i)) == $past(expire_i)));

  // R6
  sum_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|expire_i) |=> sum_q);

  // R9
  sum_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q && !clr_sum_i) |=> sum_q);
endmodule

// File: rtl/idle_standby_bank.sv
module idle_standby_bank #(
  parameter int N_DEV = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   freeze_i,
  input  logic [N_DEV-1:0]       en_i,
  input  logic [N_DEV-1:0]       access_i,
  input  logic [N_DEV*CNT_W-1:0] reload_i,
  input  logic [N_DEV-1:0]       clr_i,
  input  logic                   clr_sum_i,
  output logic [N_DEV-1:0]       stat_o,
  output logic                   sum_stat_o,
  output logic                   smi_o
);
  logic [N_DEV-1:0] expire;

  for (genvar d = 0; d < N_DEV; d++) begin : g_tmr
    idle_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .freeze_i (freeze_i),
      .en_i     (en_i[d]),
      .access_i (access_i[d]),
      .reload_i (reload_i[d*CNT_W +: CNT_W]),
      .expire_o (expire[d])
    );
  end

  standby_status #(.N_DEV(N_DEV)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .clr_i     (clr_i),
    .clr_sum_i (clr_sum_i),
    .en_i      (en_i),
    .stat_o    (stat_o),
    .sum_o     (sum_stat_o),
    .smi_o     (smi_o)
  );

  // R10
  smi_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> (|(stat_o & en_i)));

  // R7
  no_expire_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~en_i & ~$past(en_i) & ~$past(stat_o) & ~clr_i)) |-> ((stat_o & ~en_i & ~$past(en_i) & ~$past(stat_o)) == '0));
endmodule

// File: tb/sim_idle_standby_bank.sv
`timescale 1ns/1ps
module sim_idle_standby_bank;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, freeze = 1'b0, clr_sum = 1'b0;
  logic [N-1:0] en = '0, acc = '0, clr = '0;
  logic [N*W-1:0] rl = '0;
  logic [N-1:0] stat;
  logic sum, smi;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  idle_standby_bank #(.N_DEV(N), .CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freeze_i(freeze),
    .en_i(en), .access_i(acc), .reload_i(rl), .clr_i(clr),
    .clr_sum_i(clr_sum), .stat_o(stat), .sum_stat_o(sum), .smi_o(smi)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0; cyc();
    end
  endtask

  // disable, clear everything, load reloads and enable mask
  task automatic arm(logic [N*W-1:0] vals, logic [N-1:0] m);
    en = '0; clr = '1; clr_sum = 1'b1; cyc();
    clr = '0; clr_sum = 1'b0; rl = vals; en = m; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] r [N];
    int mx;
    logic [N-1:0] ex;
    repeat (3) cyc();
    chk("reset stat", 32'(stat), 0);
    chk("reset sum", 32'(sum), 0);
    chk("reset smi", 32'(smi), 0);
    rst_n = 1'b1; cyc();

    // sweep R2 R3 R6 R10: expected status from reload and tick count
    for (int b = 0; b < 40; b++) begin
      mx = 0;
      for (int d = 0; d < N; d++) begin
        if (b == 0) r[d] = (d == 0) ? 8'd0 : (d == 1) ? 8'd1 : (d == 2) ? 8'd2 : 8'd255;
        else r[d] = W'((b * 37 + d * 71) % 256);
        if (int'(r[d]) > mx) mx = int'(r[d]);
      end
      arm({r[3], r[2], r[1], r[0]}, '1);
      for (int t = 1; t <= mx + 2; t++) begin
        do_tick(1);
        for (int d = 0; d < N; d++) ex[d] = (r[d] != 0) && (t >= int'(r[d]));
        chk("R2 R3 stat", 32'(stat), 32'(ex));
        chk("R6 sum", 32'(sum), 32'(|ex));
        chk("R10 smi", 32'(smi), 32'(|ex));
      end
    end

    // R1: no ticks, no progress
    arm({24'd0, 8'd1}, 4'b0001);
    repeat (20) cyc();
    chk("R1 idle", 32'(stat), 0);
    do_tick(1);
    chk("R1 one tick", 32'(stat), 1);

    // R5 freeze
    arm({24'd0, 8'd3}, 4'b0001);
    do_tick(2);
    freeze = 1'b1; do_tick(5);
    chk("R5 frozen", 32'(stat), 0);
    freeze = 1'b0; do_tick(1);
    chk("R5 resume", 32'(stat), 1);

    // R4 access reload
    arm({24'd0, 8'd3}, 4'b0001);
    do_tick(2);
    acc = 4'b0001; cyc(); acc = '0;
    do_tick(2);
    chk("R4 access", 32'(stat), 0);
    do_tick(1);
    chk("R4 access expiry", 32'(stat), 1);

    // R4 rising enable reload
    arm({24'd0, 8'd3}, 4'b0001);
    do_tick(2);
    en = '0; cyc(); en = 4'b0001; cyc();
    do_tick(2);
    chk("R4 re-enable", 32'(stat), 0);
    do_tick(1);
    chk("R4 re-enable expiry", 32'(stat), 1);

    // R11 access wins over expiring tick
    arm({24'd0, 8'd2}, 4'b0001);
    do_tick(1);
    tick = 1'b1; acc = 4'b0001; cyc(); tick = 1'b0; acc = '0; cyc();
    chk("R11 collide", 32'(stat), 0);
    do_tick(1);
    chk("R11 after", 32'(stat), 0);
    do_tick(1);
    chk("R11 expiry", 32'(stat), 1);

    // R7 disabled device
    arm({24'd0, 8'd1}, 4'b0000);
    acc = 4'b0001; cyc(); acc = '0;
    do_tick(5);
    chk("R7 stat", 32'(stat), 0);
    chk("R7 smi", 32'(smi), 0);

    // R8 R9 R10
    arm({8'd0, 8'd0, 8'd1, 8'd1}, 4'b0011);
    do_tick(1);
    chk("R6 both", 32'(stat), 3);
    clr = 4'b0001; cyc(); clr = '0;
    chk("R9 clear one", 32'(stat), 2);
    chk("R9 sum kept", 32'(sum), 1);
    do_tick(3);
    chk("R8 stays idle", 32'(stat), 2);
    en = 4'b0001; cyc();
    chk("R10 masked", 32'(smi), 0);
    chk("R9 sticky", 32'(stat), 2);
    en = 4'b0011; cyc();
    chk("R10 unmasked", 32'(smi), 1);
    clr_sum = 1'b1; cyc(); clr_sum = 1'b0;
    chk("R9 sum clear", 32'(sum), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule